// File: doc/BRIEF.md
# Wait-State Ready Generator

This block ends every cycle of a non-pipelined processor bus. It watches the active-low address strobe. When it sees the strobe while idle, it samples the cycle's address and memory/IO type and decodes them into one of four device regions. Each region has its own wait-state count, set by a parameter. A one-hot shift register is loaded with that count and shifts once per clock. When the marker reaches the bottom stage, the active-low ready output is driven for exactly one clock. An address that matches no device falls into a default region, so every cycle ends.

For the duration of a cycle the block also drives an active-low 16-bit bus-width indication for regions that hold 16-bit devices. It drives an activity output that can light an indicator while cycles are running. A strobe that arrives while a cycle is in progress is ignored. The earliest accepted strobe is the one in the clock that follows the ready clock.

Top module: `wsr_ready_gen`

## Requirements
- R1: While synchronous reset is high and in the clock after it, `ready_n` and `bs16_n` are 1 and `bus_led` is 0.
- R2: A memory cycle (`mio_n`=1) with `addr[ADDR_W-1:ADDR_W-2]`=2'b00 selects the fast region. `ready_n` is low in the clock right after the strobe clock (2 clocks inclusive, 0 waits), and `bs16_n` is 1.
- R3: A memory cycle with top address bits 2'b01 selects the slow region. `ready_n` is low 2+SLOW_WS clocks after the strobe clock, counted inclusively (default 2 waits). `bs16_n` is 0 and stays stable through the cycle.
- R4: An I/O cycle (`mio_n`=0) selects the I/O region at any address. `ready_n` is low 2+IO_WS clocks after the strobe clock, counted inclusively (default 4 waits), and `bs16_n` is 0.
- R5: A memory cycle with top address bits 2'b10 or 2'b11 falls into the default region. It still ends, after DFLT_WS waits (default 1), with `bs16_n` 1.
- R6: `ready_n` is low for exactly one clock per cycle, then returns to 1.
- R7: A low `ads_n` during an unfinished cycle neither restarts the cycle nor produces a second ready.
- R8: A strobe in the clock right after the ready clock is accepted as a new cycle.
- R9: `bus_led` is 1 from the clock after the strobe through the ready clock, and 0 when idle.
- R10: Reset in the middle of a cycle aborts it: no ready follows and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ads_n | input | 1 | Address strobe, active low |
| mio_n | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| addr | input | ADDR_W | Cycle address (word address bits) |
| ready_n | output | 1 | Cycle-end signal, active low, one clock |
| bs16_n | output | 1 | 16-bit bus width for the current cycle, active low |
| bus_led | output | 1 | Bus activity indicator |

## Verification
The hardest case to reach is a strobe that arrives while a long cycle is still waiting. A real processor never does this, and it is the one case where a careless design would restart the shift register. The bench drives a second, low strobe with an I/O address in a wait clock of a slow-memory cycle. It then checks that ready still lands on the slow-memory clock and that no further ready follows. Mid-cycle reset and strobes in the clock right after ready are reached the same way, by driving the strobe directly and counting clocks against the region's wait count.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

    typedef enum logic [1:0] {
        RG_FAST = 2'd0,
        RG_SLOW = 2'd1,
        RG_IO   = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } cyc_state_e;

    typedef struct packed {
        region_e region;
        logic    is16;
    } cyc_info_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic cyc_info_t classify(input logic is_mem, input logic [1:0] sel);
        cyc_info_t r;
        if (!is_mem) begin
            r.region = RG_IO;
            r.is16   = 1'b1;
        end else begin
            unique case (sel)
                2'b00:   begin r.region = RG_FAST; r.is16 = 1'b0; end
                2'b01:   begin r.region = RG_SLOW; r.is16 = 1'b1; end
                default: begin r.region = RG_NONE; r.is16 = 1'b0; end
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/wsr_decoder.sv
module wsr_decoder
    import wsr_pkg::*;
#(
    parameter int ADDR_W  = 30,
    parameter int PW      = 3,
    parameter int FAST_WS = 0,
    parameter int SLOW_WS = 2,
    parameter int IO_WS   = 4,
    parameter int DFLT_WS = 1
) (
    input  logic              mio_n,
    input  logic [ADDR_W-1:0] addr,
    output cyc_info_t         info,
    output logic [PW-1:0]     waits
);
    localparam int SEL_W = 2;

    logic [SEL_W-1:0] sel;
    assign sel  = addr[ADDR_W-1 -: SEL_W];
    assign info = classify(mio_n, sel);

    always_comb begin
        unique case (info.region)
            RG_FAST: waits = PW'(FAST_WS);
            RG_SLOW: waits = PW'(SLOW_WS);
            RG_IO:   waits = PW'(IO_WS);
            default: waits = PW'(DFLT_WS);
        endcase
    end

    always_comb begin
        AST_WIDE_REGION: assert (!info.is16 || info.region == RG_SLOW || info.region == RG_IO); // R3
    end
endmodule

// File: rtl/wsr_shift.sv
module wsr_shift #(
    parameter int SR_W = 5,
    parameter int PW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [PW-1:0] pos,
    output logic          fire,
    output logic          empty
);
    logic [SR_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)       sr_q <= '0;
        else if (load) sr_q <= SR_W'(1) << pos;
        else           sr_q <= sr_q >> 1;
    end

    assign fire  = sr_q[0];
    assign empty = (sr_q == '0);

    AST_MARKER_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(sr_q)); // R6
    AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst) load |-> empty); // R7
endmodule

// File: rtl/wsr_cycle_ctl.sv
module wsr_cycle_ctl
    import wsr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ads_n,
    input  logic is16,
    input  logic fire,
    output logic load,
    output logic busy,
    output logic bs16_n
);
    cyc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (!ads_n) begin
                load    = 1'b1;
                state_d = ST_WAIT;
            end
            ST_WAIT: if (fire) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bs16_n  <= 1'b1;
        end else begin
            state_q <= state_d;
            if (load)      bs16_n <= ~is16;
            else if (fire) bs16_n <= 1'b1;
        end
    end

    assign busy = (state_q == ST_WAIT);

    AST_FIRE_IN_CYCLE: assert property (@(posedge clk) disable iff (rst) fire |-> busy); // R9
    AST_WIDTH_STEADY: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy) && !$past(fire)) |-> $stable(bs16_n)); // R3
    AST_IDLE_NARROW: assert property (@(posedge clk) disable iff (rst) !busy |-> bs16_n); // R5
endmodule

// File: rtl/wsr_ready_gen.sv
module wsr_ready_gen
    import wsr_pkg::*;
#(
    parameter int ADDR_W  = 30,
    parameter int FAST_WS = 0,
    parameter int SLOW_WS = 2,
    parameter int IO_WS   = 4,
    parameter int DFLT_WS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ads_n,
    input  logic              mio_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              ready_n,
    output logic              bs16_n,
    output logic              bus_led
);
    localparam int MAX_WS = max4(FAST_WS, SLOW_WS, IO_WS, DFLT_WS);
    localparam int SR_W   = MAX_WS + 1;
    localparam int PW     = (SR_W > 1) ? $clog2(SR_W) : 1;

    cyc_info_t     info;
    logic [PW-1:0] waits;
    logic          load, fire, empty, busy;

    wsr_decoder #(
        .ADDR_W(ADDR_W), .PW(PW),
        .FAST_WS(FAST_WS), .SLOW_WS(SLOW_WS), .IO_WS(IO_WS), .DFLT_WS(DFLT_WS)
    ) u_dec (
        .mio_n(mio_n), .addr(addr), .info(info), .waits(waits)
    );

    wsr_cycle_ctl u_ctl (
        .clk(clk), .rst(rst), .ads_n(ads_n), .is16(info.is16), .fire(fire),
        .load(load), .busy(busy), .bs16_n(bs16_n)
    );

    wsr_shift #(.SR_W(SR_W), .PW(PW)) u_sr (
        .clk(clk), .rst(rst), .load(load), .pos(waits), .fire(fire), .empty(empty)
    );

    assign ready_n = ~fire;
    assign bus_led = busy;

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (ready_n && bs16_n && !bus_led)); // R1
    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst) !ready_n |=> ready_n); // R6
    AST_BUSY_TRACKS_SR: assert property (@(posedge clk) disable iff (rst) bus_led == !empty); // R9
endmodule

// File: tb/wsr_ready_gen_test.sv
module wsr_ready_gen_test;
    localparam int AW = 30;

    logic          clk = 1'b0;
    logic          rst;
    logic          ads_n;
    logic          mio_n;
    logic [AW-1:0] addr;
    logic          ready_n, bs16_n, bus_led;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    wsr_ready_gen #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .ads_n(ads_n), .mio_n(mio_n), .addr(addr),
        .ready_n(ready_n), .bs16_n(bs16_n), .bus_led(bus_led)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Entered at a negedge with the block idle; leaves at a negedge one clock after ready.
    task automatic run_cycle(input string req, input logic mem, input logic [1:0] top,
                             input int waits, input logic exp_bs16_n);
        int seen;
        seen = -1;
        mio_n = mem;
        addr  = {top, 28'h0ABC123};
        ads_n = 1'b0;
        @(posedge clk); @(negedge clk);
        ads_n = 1'b1;
        addr  = '0;
        for (int n = 1; n <= waits + 6; n++) begin
            if (!ready_n) begin
                if (seen < 0) seen = n;
                check(req, "bs16_n at ready", int'(bs16_n), int'(exp_bs16_n));
                check("R9", "bus_led at ready", int'(bus_led), 1);
                @(posedge clk); @(negedge clk);
                check("R6", "ready_n after ready clock", int'(ready_n), 1);
                check("R9", "bus_led idle", int'(bus_led), 0);
                break;
            end
            check("R9", "bus_led during wait", int'(bus_led), 1);
            @(posedge clk); @(negedge clk);
        end
        check(req, "clocks strobe-to-ready inclusive", seen + 1, waits + 2);
    endtask

    task automatic t_reset;
        rst = 1'b1; ads_n = 1'b1; mio_n = 1'b1; addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "ready_n in reset", int'(ready_n), 1);
        check("R1", "bs16_n in reset", int'(bs16_n), 1);
        check("R1", "bus_led in reset", int'(bus_led), 0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1", "ready_n after reset", int'(ready_n), 1);
    endtask

    task automatic t_regions;
        run_cycle("R2", 1'b1, 2'b00, 0, 1'b1);
        run_cycle("R3", 1'b1, 2'b01, 2, 1'b0);
        run_cycle("R4", 1'b0, 2'b00, 4, 1'b0);
        run_cycle("R4", 1'b0, 2'b11, 4, 1'b0);
        run_cycle("R5", 1'b1, 2'b10, 1, 1'b1);
        run_cycle("R5", 1'b1, 2'b11, 1, 1'b1);
    endtask

    task automatic t_back_to_back;
        // each run_cycle starts a strobe in the clock right after the previous ready
        run_cycle("R8", 1'b1, 2'b01, 2, 1'b0);
        run_cycle("R8", 1'b1, 2'b00, 0, 1'b1);
        run_cycle("R8", 1'b1, 2'b00, 0, 1'b1);
        run_cycle("R8", 1'b0, 2'b01, 4, 1'b0);
        run_cycle("R8", 1'b1, 2'b11, 1, 1'b1);
    endtask

    task automatic t_intrude;
        int readies, first;
        readies = 0; first = -1;
        mio_n = 1'b1; addr = {2'b01, 28'h0000040};
        ads_n = 1'b0;
        @(posedge clk); @(negedge clk);
        // stray strobe in a wait clock, I/O address
        mio_n = 1'b0; addr = '0; ads_n = 1'b0;
        for (int n = 1; n <= 10; n++) begin
            if (n == 2) ads_n = 1'b1;
            if (!ready_n) begin
                readies++;
                if (first < 0) first = n;
            end
            @(posedge clk); @(negedge clk);
        end
        check("R7", "ready clock of slow cycle", first + 1, 4);
        check("R7", "number of readies", readies, 1);
        check("R7", "bs16_n idle after", int'(bs16_n), 1);
    endtask

    task automatic t_mid_reset;
        int readies;
        readies = 0;
        mio_n = 1'b0; addr = '0; ads_n = 1'b0;
        @(posedge clk); @(negedge clk);
        ads_n = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        check("R10", "bus_led after abort", int'(bus_led), 0);
        for (int n = 0; n < 8; n++) begin
            if (!ready_n) readies++;
            @(posedge clk); @(negedge clk);
        end
        check("R10", "readies after abort", readies, 0);
        run_cycle("R10", 1'b1, 2'b00, 0, 1'b1);
    endtask

    initial begin
        ads_n = 1'b1; mio_n = 1'b1; addr = '0; rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_regions();
        t_back_to_back();
        t_intrude();
        t_mid_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule